// File: doc/BRIEF.md
# Serial Receive Path with Per-Character Error Tags

This block turns an oversampled asynchronous serial line into bytes. A free-running
oversample strobe (sixteen strobes per bit) paces a frame engine that finds the start
bit, confirms it at mid-bit and samples each following bit at its centre. The frame
format comes from a configuration input: five to eight data bits sent least
significant bit first, parity optional (even, odd, or a fixed "stick" value), and one
or two stop bits.

Each finished character goes into a sixteen-entry receive queue. The character's
framing, parity and break tags are stored beside it. The read port always presents
the oldest entry as eleven bits. A four-bit sticky error register collects the tags
of characters as software reads them, plus an overrun flag. One clear strobe zeroes
all four bits.

A line held low for a whole character is reported as a break. It yields exactly one
zero character. The engine then ignores the line until it goes high again and a new
start bit arrives. A character that completes while the queue is full is dropped. The
overrun flag is set and no stored entry changes.

Top module: `uart_rx_err_top`

## Requirements
- R1: After reset, `rd_valid` is 0 and `err_status` is 0.
- R2: The read word is laid out as follows. Bits 7:0 hold the data, received LSB first and zero-extended above the configured length (`cfg_len` 0..3 selects 5..8 bits). Bit 8 is the framing tag, bit 9 the parity tag and bit 10 the break tag. Entries come out in arrival order.
- R3: With parity enabled and stick parity off, the expected parity bit makes the count of ones over data plus parity even when `cfg_even`=1, and odd when `cfg_even`=0. A mismatch sets the parity tag.
- R4: A stop bit sampled as 0 sets the framing tag. With `cfg_two_stop`=1 this applies to either stop bit.
- R5: If the start, data, parity and first stop bit all sample 0, exactly one entry is queued. It holds data 0, break tag 1, and framing and parity tags 0.
- R6: After a break, no further entry is queued while the line stays low. The next character after the line returns high is received normally.
- R7: A low pulse that is high again at the mid-bit check of the start bit queues nothing.
- R8: If a character completes while 16 entries are stored, it is discarded, `err_status` bit 3 (overrun) is set, and the stored entries are read back unchanged.
- R9: `err_status` bit 0 (framing), bit 1 (parity) and bit 2 (break) are set when an entry carrying that tag is popped. They stay set until cleared. Bits 7:4 are always 0.
- R10: A one-cycle `err_clr` pulse zeroes bits 3:0. An error event in the same cycle is still recorded.
- R11: The engine advances only on cycles with `os_tick` high. A slower strobe stretches the bit time in proportion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample strobe, 16 per bit time |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length: 0..3 selects 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_even | input | 1 | Even parity select |
| cfg_stick | input | 1 | Stick parity: expected bit is the inverse of cfg_even |
| cfg_two_stop | input | 1 | Two stop bits |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 11 | Head entry: {break, parity, framing, data[7:0]} |
| err_status | output | 8 | Sticky errors in bits 3:0, bits 7:4 zero |
| err_clr | input | 1 | Clear strobe for the error bits |

## Verification
The hardest state to reach is overrun: the queue must be completely full when one more
character lands. The stimulus therefore sends seventeen characters with no reads in
between, then drains all sixteen entries and compares each one. Break recovery is the
other awkward case. The line is held low for several character times and a normal
character follows immediately, so any second zero entry or lost character shows up in
the queue contents.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receive path.
// Assumes: data field at most 8 bits; tags sit above the data in the queue word.
package uart_rx_pkg;
    typedef struct packed {
        logic       brk;
        logic       par_err;
        logic       frm_err;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2, ST_BRKW
    } rx_state_t;
endpackage

// File: rtl/rx_frame_engine.sv
// Frame engine: synchronises the line, finds and confirms start bits, samples bits
// at their centre and emits one tagged character per frame.
// Assumes: os_tick comes OSR times per bit; configuration is stable during a frame.
module rx_frame_engine
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      os_tick,
    input  logic      rx_in,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_even,
    input  logic      cfg_stick,
    input  logic      cfg_two_stop,
    output logic      push,
    output rx_entry_t push_entry
);
    localparam int CW   = $clog2(OSR);
    localparam int MID  = OSR / 2 - 1;
    localparam int LAST = OSR - 1;

    logic          rx_meta, rx_s;
    rx_state_t     state;
    logic [CW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          zero_acc, par_seen, fe1;
    logic          bit_pt, exp_par, pe_now;
    logic [2:0]    last_idx;

    // Derive the sample point, last data index and parity verdict
    always_comb begin
        bit_pt   = (tcnt == CW'(LAST));
        last_idx = 3'd4 + {1'b0, cfg_len};
        exp_par  = cfg_stick ? ~cfg_even : (cfg_even ? ^shreg : ~(^shreg));
        pe_now   = cfg_par_en && (par_seen != exp_par);
    end

    // Two-flop synchroniser on the serial line, idle high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= rx_in;
            rx_s    <= rx_meta;
        end
    end

    // Frame state machine, advanced on oversample strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tcnt       <= '0;
            bidx       <= '0;
            shreg      <= '0;
            zero_acc   <= 1'b0;
            par_seen   <= 1'b0;
            fe1        <= 1'b0;
            push       <= 1'b0;
            push_entry <= '0;
        end else begin
            push <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_IDLE: begin
                        if (!rx_s) begin
                            state <= ST_START;
                            tcnt  <= '0;
                        end
                    end
                    ST_START: begin
                        if (tcnt == CW'(MID)) begin
                            tcnt <= '0;
                            if (!rx_s) begin
                                state    <= ST_DATA;
                                bidx     <= '0;
                                shreg    <= '0;
                                zero_acc <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        tcnt <= bit_pt ? '0 : tcnt + 1'b1;
                        if (bit_pt) begin
                            shreg[bidx] <= rx_s;
                            zero_acc    <= zero_acc & ~rx_s;
                            if (bidx == last_idx)
                                state <= cfg_par_en ? ST_PAR : ST_STOP1;
                            else
                                bidx <= bidx + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        tcnt <= bit_pt ? '0 : tcnt + 1'b1;
                        if (bit_pt) begin
                            par_seen <= rx_s;
                            zero_acc <= zero_acc & ~rx_s;
                            state    <= ST_STOP1;
                        end
                    end
                    ST_STOP1: begin
                        tcnt <= bit_pt ? '0 : tcnt + 1'b1;
                        if (bit_pt) begin
                            if (zero_acc && !rx_s) begin
                                push       <= 1'b1;
                                push_entry <= '{brk: 1'b1, par_err: 1'b0, frm_err: 1'b0, data: 8'h00};
                                state      <= ST_BRKW;
                            end else if (cfg_two_stop) begin
                                fe1   <= ~rx_s;
                                state <= ST_STOP2;
                            end else begin
                                push       <= 1'b1;
                                push_entry <= '{brk: 1'b0, par_err: pe_now, frm_err: ~rx_s, data: shreg};
                                state      <= ST_IDLE;
                            end
                        end
                    end
                    ST_STOP2: begin
                        tcnt <= bit_pt ? '0 : tcnt + 1'b1;
                        if (bit_pt) begin
                            push       <= 1'b1;
                            push_entry <= '{brk: 1'b0, par_err: pe_now, frm_err: fe1 | ~rx_s, data: shreg};
                            state      <= ST_IDLE;
                        end
                    end
                    ST_BRKW: begin
                        if (rx_s) state <= ST_IDLE;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // R5
    break_entry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && push_entry.brk) |-> (push_entry.data == 8'h00 && !push_entry.frm_err && !push_entry.par_err));

    // R7
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && os_tick && tcnt == CW'(MID) && rx_s) |=> (state == ST_IDLE));

    // R6
    break_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BRKW && !rx_s) |=> (state == ST_BRKW && !push));

    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !os_tick |=> ($stable(tcnt) && !push));
endmodule

// File: rtl/rx_char_fifo.sv
// Receive queue: first-in first-out store with show-ahead head output.
// Assumes: a write while full is refused by the queue; the caller sees `full`.
module rx_char_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    // Qualify accesses against occupancy
    always_comb begin
        full  = (count == (AW+1)'(DEPTH));
        empty = (count == '0);
        do_wr = wr_en && !full;
        do_rd = rd_en && !empty;
        rd_data = mem[rptr];
    end

    // Storage writes
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));

    // R8
    full_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> ($stable(count) && $stable(rptr)));
endmodule

// File: rtl/rx_err_status.sv
// Sticky error register: records tags of popped entries and overruns.
// Assumes: clear and set in one cycle leave the new event recorded.
module rx_err_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pop_evt,
    input  logic [2:0] pop_tags,
    input  logic       ovr_evt,
    input  logic       clr,
    output logic [3:0] bits
);
    logic [3:0] set_vec;

    // Collect this cycle's error events
    always_comb begin
        set_vec = {ovr_evt, pop_evt ? pop_tags : 3'b000};
    end

    // Clear-then-set update of the sticky bits
    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= (clr ? 4'b0000 : bits) | set_vec;
    end

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !pop_evt && !ovr_evt) |=> (bits == 4'b0000));

    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((bits & $past(bits)) == $past(bits)));

    // R8
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> bits[3]);
endmodule

// File: rtl/uart_rx_err_top.sv
// Top of the serial receive path: frame engine, receive queue and error register.
// Assumes: os_tick is supplied externally at OSR strobes per bit.
module uart_rx_err_top
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        os_tick,
    input  logic        rx_in,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_par_en,
    input  logic        cfg_even,
    input  logic        cfg_stick,
    input  logic        cfg_two_stop,
    input  logic        rd_en,
    output logic        rd_valid,
    output logic [10:0] rd_data,
    output logic [7:0]  err_status,
    input  logic        err_clr
);
    localparam int EW = $bits(rx_entry_t);

    logic      push, full, empty;
    rx_entry_t push_entry, head;
    logic [3:0] err_bits;

    rx_frame_engine #(.OSR(OSR)) u_engine (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop),
        .push(push), .push_entry(push_entry)
    );

    rx_char_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(push), .wr_data(push_entry),
        .rd_en(rd_en), .rd_data(head), .full(full), .empty(empty)
    );

    rx_err_status u_status (
        .clk(clk), .rst_n(rst_n),
        .pop_evt(rd_en && !empty),
        .pop_tags({head.brk, head.par_err, head.frm_err}),
        .ovr_evt(push && full), .clr(err_clr), .bits(err_bits)
    );

    // Drive the read and status ports
    always_comb begin
        rd_valid   = !empty;
        rd_data    = head;
        err_status = {4'b0000, err_bits};
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && err_status == 8'h00));
endmodule

// File: tb/test_uart_rx_err_top.sv
`timescale 1ns/1ps
module test_uart_rx_err_top;
    logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b1, rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0, cfg_two_stop = 1'b0;
    logic rd_en = 1'b0, err_clr = 1'b0;
    logic rd_valid;
    logic [10:0] rd_data;
    logic [7:0] err_status;

    logic [10:0] mq[$];
    logic [3:0]  mstat = 4'h0;
    int checks = 0, errs = 0;
    bit quiet = 0, half = 0, done = 0;

    always #2.5 clk = ~clk;

    uart_rx_err_top i_uart_rx_err_top (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rx_in(rx_in),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
        .cfg_stick(cfg_stick), .cfg_two_stop(cfg_two_stop),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
        .err_status(err_status), .err_clr(err_clr)
    );

    // R11: strobe every clock, or every other clock at half rate
    always @(posedge clk) os_tick <= half ? ~os_tick : 1'b1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model while the line is quiet
    always @(negedge clk) begin
        if (quiet) begin
            check("R9 status", {24'h0, err_status}, {28'h0, mstat});
            check("R2 rd_valid", {31'h0, rd_valid}, {31'h0, mq.size() > 0});
            if (mq.size() > 0) check("R2 head", {21'h0, rd_data}, {21'h0, mq[0]});
        end
    end

    function automatic logic exp_par(input logic [7:0] d);
        if (cfg_stick) return ~cfg_even;
        return cfg_even ? ^d : ~(^d);
    endfunction

    task automatic hold(input logic v, input int n);
        rx_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic tx(input logic [7:0] d, input bit bad_par, input bit bad_stop, input int cpb);
        int nb;
        logic [7:0] dm;
        nb = 5 + cfg_len;
        dm = d & ((8'h01 << nb) - 1);
        quiet = 0;
        hold(1'b0, cpb);
        for (int i = 0; i < nb; i++) hold(dm[i], cpb);
        if (cfg_par_en) hold(exp_par(dm) ^ bad_par, cpb);
        hold(~bad_stop, cpb);
        if (cfg_two_stop) hold(1'b1, cpb);
        rx_in = 1'b1;
        if (mq.size() >= 16) mstat[3] = 1'b1;
        else mq.push_back({1'b0, bad_par && cfg_par_en, bad_stop, dm});
        repeat (20) @(negedge clk);
        quiet = 1;
    endtask

    task automatic pop(input bit with_clr);
        logic [10:0] e;
        @(negedge clk);
        rd_en = 1'b1;
        err_clr = with_clr;
        @(posedge clk);
        #1;
        rd_en = 1'b0;
        err_clr = 1'b0;
        e = mq.pop_front();
        if (with_clr) mstat = 4'h0;
        mstat[0] |= e[8];
        mstat[1] |= e[9];
        mstat[2] |= e[10];
    endtask

    task automatic do_clr();
        @(negedge clk);
        err_clr = 1'b1;
        @(posedge clk);
        #1;
        err_clr = 1'b0;
        mstat = 4'h0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 rd_valid", {31'h0, rd_valid}, 32'h0);
        check("R1 status", {24'h0, err_status}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", {23'h0, rd_valid, err_status}, 32'h0);
        quiet = 1;

        // R2: 8 data bits, no parity, one stop
        tx(8'hA5, 0, 0, 16);
        tx(8'h3C, 0, 0, 16);
        check("R2 two queued", mq.size(), 2);
        pop(0); pop(0);

        // R3: 7 bits even parity, good then bad
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_even = 1'b1;
        tx(8'h5B, 0, 0, 16);
        tx(8'h22, 1, 0, 16);
        pop(0); pop(0);
        check("R9 parity sticky", {31'h0, err_status[1]}, 32'h1);

        // R3 odd, R4: 6 bits, two stop bits, bad first stop
        cfg_len = 2'd1; cfg_even = 1'b0; cfg_two_stop = 1'b1;
        tx(8'h2D, 0, 0, 16);
        tx(8'h11, 0, 1, 16);
        tx(8'h07, 1, 0, 16);
        pop(0); pop(0); pop(0);
        check("R4 framing sticky", {31'h0, err_status[0]}, 32'h1);

        // R3: stick parity, 5 bits
        cfg_len = 2'd0; cfg_two_stop = 1'b0; cfg_stick = 1'b1;
        tx(8'h1F, 0, 0, 16);
        tx(8'h00, 0, 0, 16);
        cfg_even = 1'b1;
        tx(8'h13, 0, 0, 16);
        tx(8'h0A, 1, 0, 16);
        pop(0); pop(0); pop(0); pop(0);

        // R10: clear all bits
        do_clr();
        check("R10 cleared", {24'h0, err_status}, 32'h0);

        // R5, R6: long break, then a normal character
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_stick = 1'b0; cfg_even = 1'b0;
        quiet = 0;
        hold(1'b0, 16 * 10 * 4);
        rx_in = 1'b1;
        repeat (20) @(negedge clk);
        mq.push_back(11'h400);
        check("R6 one break entry", {31'h0, rd_valid}, 32'h1);
        quiet = 1;
        tx(8'h81, 0, 0, 16);
        check("R6 entries after break", mq.size(), 2);
        pop(0);
        check("R5 break status", {28'h0, err_status[3:0]}, 32'h4);
        pop(0);

        // R7: short low glitch
        quiet = 0;
        hold(1'b0, 3);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        quiet = 1;
        check("R7 glitch ignored", {31'h0, rd_valid}, 32'h0);

        // R11: half-rate strobe, doubled bit time
        half = 1;
        repeat (4) @(negedge clk);
        tx(8'h96, 0, 0, 32);
        half = 0;
        repeat (4) @(negedge clk);
        pop(0);

        // R8: overrun with a full queue
        do_clr();
        for (int i = 0; i < 17; i++) tx(8'h40 + 8'(i), 0, 0, 16);
        check("R8 overrun flag", {31'h0, err_status[3]}, 32'h1);
        check("R8 depth kept", mq.size(), 16);
        for (int i = 0; i < 16; i++) pop(0);
        check("R8 drained", {31'h0, rd_valid}, 32'h0);

        // R10: clear in the same cycle as popping a framing-tagged entry
        tx(8'h55, 0, 1, 16);
        pop(1);
        repeat (2) @(negedge clk);
        check("R10 set wins over clear", {24'h0, err_status}, 32'h1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule